// File: doc/BRIEF.md
# Serial Port Receive Byte Queue with Mode Control

This block holds the bytes a serial receiver has assembled until software reads them from the data register. A push strobe offers one byte at a time. A data-register read removes the oldest held byte. The head byte is presented combinationally in the same cycle as the read, so the read can complete in a single cycle.

An 8-bit control register selects how much of the storage can be used. With its enable bit clear, the block acts as a single holding byte. With the enable bit set, all `DEPTH` entries are available. A write that changes the enable bit empties the storage. A write that keeps the enable bit set and also sets the receiver-reset bit empties it as well.

A two-state machine records the mode:
- `MODE_SINGLE` is the reset state.
- The *enable write* transition (a control write with bit 0 set) moves from `MODE_SINGLE` to `MODE_QUEUE`.
- The *disable write* transition (a control write with bit 0 clear) moves from `MODE_QUEUE` back to `MODE_SINGLE`.
- Any other control write leaves the state where it is (*hold*).

The block reports the number of held bytes and a data-ready flag. It also gives a one-cycle overrun pulse whenever a byte is lost.

Top module: `rx_queue_ctl`

## Requirements
- R1: After reset the queue is empty and in single-byte mode: count 0, ready low, stored control byte 0x00, overrun low.
- R2: In single-byte mode at most one byte is held. A push while one byte is held is dropped, and the held byte is returned unchanged by the next read.
- R3: In queue mode up to DEPTH bytes are held and read back in push order. A push when DEPTH bytes are held is dropped.
- R4: A control write whose bit 0 differs from the current mode empties the queue. This applies in both directions. The usable depth becomes DEPTH after enabling and 1 after disabling.
- R5: A control write with bit 0 clear stores 0x00 as the control byte, whatever its other bits are.
- R6: A control write with bit 0 set stores only bits 7, 6, 3 and 0 of the written value (mask 0xC9).
- R7: A control write with bit 0 set and bit 1 set empties the queue and stays in queue mode.
- R8: The ready output is high exactly when the held byte count is greater than zero.
- R9: A read while the queue is empty returns 0x00 and leaves the count at zero.
- R10: When a push and an emptying control write occur in the same cycle, the emptying wins and the pushed byte is discarded.
- R11: A control write with bit 0 set, made in queue mode with bit 1 clear, keeps the held bytes and their order.
- R12: A dropped push raises the overrun output for exactly the one cycle that follows it. The overrun output is low at all other times.
- R13: A read and an accepted push in the same cycle leave the count unchanged. The byte read is the oldest one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Offer one received byte |
| push_data_i | input | 8 | Byte offered with push_i |
| pop_i | input | 1 | Data-register read: remove the oldest byte |
| pop_data_o | output | 8 | Oldest held byte, or 0x00 when empty |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write value |
| ctl_q_o | output | 8 | Stored control byte |
| count_o | output | $clog2(DEPTH+1) | Number of held bytes |
| ready_o | output | 1 | Data ready: count is nonzero |
| overrun_o | output | 1 | One-cycle pulse after a dropped byte |

## Verification
A wrong mode state shows up as a wrong usable depth. The second byte in single-byte mode, or the seventeenth in queue mode, is then kept or dropped incorrectly, and count and overrun differ one cycle after that push. A missed or spurious emptying shows up in the count one cycle after the control write. Pointer corruption shows up in the very next read as an out-of-order byte. The model checks count, ready, the control byte and overrun every cycle, and checks the read data on every read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_QUEUE  = 1'b1
    } rxq_mode_e;

    localparam int unsigned CTL_EN_BIT  = 0;
    localparam int unsigned CTL_CLR_BIT = 1;
    localparam logic [7:0]  CTL_KEEP    = 8'hC9;

endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    ctl_q_o,
    output logic          flush_o,
    output logic [CW-1:0] limit_o
);

    rxq_mode_e  state_q, state_d;
    logic [7:0] ctl_q;
    logic       wr_en, wr_clr;

    assign wr_en  = wdata_i[CTL_EN_BIT];
    assign wr_clr = wdata_i[CTL_CLR_BIT];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SINGLE: if (wr_i && wr_en)  state_d = MODE_QUEUE;
            MODE_QUEUE:  if (wr_i && !wr_en) state_d = MODE_SINGLE;
            default:     state_d = MODE_SINGLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_SINGLE;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        flush_o = 1'b0;
        limit_o = CW'(1);
        unique case (state_q)
            MODE_SINGLE: begin
                limit_o = CW'(1);
                flush_o = wr_i && wr_en;
            end
            MODE_QUEUE: begin
                limit_o = CW'(DEPTH);
                flush_o = wr_i && (!wr_en || wr_clr);
            end
            default: begin
                limit_o = CW'(1);
                flush_o = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          ctl_q <= 8'h00;
        else if (wr_i) begin
            if (wr_en)       ctl_q <= wdata_i & CTL_KEEP;
            else             ctl_q <= 8'h00;
        end
    end

    assign ctl_q_o = ctl_q;

    a_r5_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wr_en) |=> (ctl_q_o == 8'h00));

    a_r6_keep_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q_o != 8'h00) |-> (ctl_q_o[CTL_EN_BIT] && ((ctl_q_o & ~CTL_KEEP) == 8'h00)));

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [7:0]    push_data_i,
    input  logic          pop_i,
    input  logic          flush_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW-1:0] count_o,
    output logic [7:0]    head_o,
    output logic          overrun_o
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0] count;
    logic          accept, drop, take, ovr_q;

    assign accept = push_i && !flush_i && (count < limit_i);
    assign drop   = push_i && !flush_i && (count >= limit_i);
    assign take   = pop_i  && !flush_i && (count != '0);

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wr_nxt = wr_ptr + AW'(1);
            assign rd_nxt = rd_ptr + AW'(1);
        end else begin : g_cmp_wrap
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_nxt;
            if (take)   rd_ptr <= rd_nxt;
            count <= count + CW'(accept) - CW'(take);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= drop;
    end

    assign count_o   = count;
    assign head_o    = (count != '0) ? mem[rd_ptr] : 8'h00;
    assign overrun_o = ovr_q;

    a_r13_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && push_i && !flush_i && count != '0 && count < limit_i) |=> (count_o == $past(count_o)));

endmodule

// File: rtl/rx_queue_ctl.sv
module rx_queue_ctl #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [7:0]    push_data_i,
    input  logic          pop_i,
    output logic [7:0]    pop_data_o,
    input  logic          ctl_wr_i,
    input  logic [7:0]    ctl_wdata_i,
    output logic [7:0]    ctl_q_o,
    output logic [CW-1:0] count_o,
    output logic          ready_o,
    output logic          overrun_o
);

    logic          flush;
    logic [CW-1:0] limit;

    rxq_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr_i),
        .wdata_i (ctl_wdata_i),
        .ctl_q_o (ctl_q_o),
        .flush_o (flush),
        .limit_o (limit)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .pop_i       (pop_i),
        .flush_i     (flush),
        .limit_i     (limit),
        .count_o     (count_o),
        .head_o      (pop_data_o),
        .overrun_o   (overrun_o)
    );

    assign ready_o = (count_o != '0);

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= limit);

    a_r4_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && (ctl_wdata_i[0] != ctl_q_o[0])) |=> (count_o == '0));

    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count_o == '0) |=> (count_o == '0));

    a_r12_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> $past(push_i));

endmodule

// File: tb/rx_queue_ctl_bench.sv
module rx_queue_ctl_bench;

    localparam int unsigned DEPTH = 16;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic [7:0]    push_data_i = 8'h00;
    logic          pop_i = 1'b0;
    logic [7:0]    pop_data_o;
    logic          ctl_wr_i = 1'b0;
    logic [7:0]    ctl_wdata_i = 8'h00;
    logic [7:0]    ctl_q_o;
    logic [CW-1:0] count_o;
    logic          ready_o;
    logic          overrun_o;

    always #2 clk = ~clk;

    rx_queue_ctl #(.DEPTH(DEPTH)) u_rx_queue_ctl (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .pop_data_o(pop_data_o),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
        .ctl_q_o(ctl_q_o), .count_o(count_o),
        .ready_o(ready_o), .overrun_o(overrun_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // scoreboard model state
    logic [7:0] exp_q[$];
    bit         m_queue_mode = 1'b0;
    logic [7:0] m_ctl = 8'h00;
    bit         m_ovr = 1'b0;

    task automatic check(string req, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // monitor: compare then advance the model once per cycle
    always @(negedge clk) begin
        if (rst_n) begin
            int  lim;
            bit  fl;
            bit  acc;
            lim = m_queue_mode ? DEPTH : 1;
            check(cur_req, int'(count_o), exp_q.size(), "count");
            check("R8", int'(ready_o), int'(exp_q.size() > 0), "ready");
            check(cur_req, int'(ctl_q_o), int'(m_ctl), "control byte");
            check("R12", int'(overrun_o), int'(m_ovr), "overrun");
            fl = ctl_wr_i && ((ctl_wdata_i[0] != m_queue_mode) || (ctl_wdata_i[0] && ctl_wdata_i[1]));
            acc = push_i && !fl && (exp_q.size() < lim);
            m_ovr = push_i && !fl && (exp_q.size() >= lim);
            if (pop_i) begin
                if (exp_q.size() > 0) begin
                    check(cur_req, int'(pop_data_o), int'(exp_q[0]), "read data");
                    if (!fl) void'(exp_q.pop_front());
                end else begin
                    check("R9", int'(pop_data_o), 0, "empty read data");
                end
            end
            if (fl) exp_q.delete();
            else if (acc) exp_q.push_back(push_data_i);
            if (ctl_wr_i) begin
                m_queue_mode = ctl_wdata_i[0];
                m_ctl = ctl_wdata_i[0] ? (ctl_wdata_i & 8'hC9) : 8'h00;
            end
        end
    end

    // driver: apply one cycle of stimulus
    task automatic cyc(bit ps, logic [7:0] d, bit pp, bit w, logic [7:0] wd);
        push_i = ps; push_data_i = d; pop_i = pp; ctl_wr_i = w; ctl_wdata_i = wd;
        @(posedge clk); #1;
        push_i = 1'b0; pop_i = 1'b0; ctl_wr_i = 1'b0;
    endtask

    task automatic push(logic [7:0] d);  cyc(1, d, 0, 0, 8'h00); endtask
    task automatic pop();                cyc(0, 8'h00, 1, 0, 8'h00); endtask
    task automatic wctl(logic [7:0] v);  cyc(0, 8'h00, 0, 1, v); endtask
    task automatic idle();               cyc(0, 8'h00, 0, 0, 8'h00); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1"; idle(); idle();

        // single-byte mode
        cur_req = "R2"; push(8'hA5); push(8'h3C); idle(); pop();
        cur_req = "R9"; pop(); pop(); idle();

        // enable queue mode with extra bits; flush and masking
        cur_req = "R2"; push(8'h11);
        cur_req = "R4"; wctl(8'hFF); idle();
        cur_req = "R6"; wctl(8'hF7); idle();
        cur_req = "R3";
        for (int i = 0; i < DEPTH + 4; i++) push(8'(i * 7 + 1));
        idle();
        for (int i = 0; i < DEPTH + 1; i++) pop();
        idle();

        // rewrite without reset bit keeps contents
        cur_req = "R11"; push(8'h21); push(8'h22); push(8'h23);
        wctl(8'h41); idle(); pop();
        cur_req = "R7"; wctl(8'h03); idle();

        // flush beats push
        cur_req = "R10"; push(8'h30); cyc(1, 8'h31, 0, 1, 8'h03); idle();

        // push and read together
        cur_req = "R13"; push(8'h40); push(8'h41);
        cyc(1, 8'h42, 1, 0, 8'h00); cyc(1, 8'h43, 1, 0, 8'h00); idle();

        // disable: flush, zero control, depth one
        cur_req = "R4"; wctl(8'hFE); idle();
        cur_req = "R2"; push(8'h55); push(8'h66); idle();
        cur_req = "R5"; wctl(8'hC8); idle(); pop(); idle();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule